// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Sequencer

This block sits between a processor-side request port and an external asynchronous static RAM. A request is a single-clock pulse carrying a direction flag, an address and, for stores, a data word. The sequencer turns it into a multi-clock strobe pattern on the memory pins. It then answers with a one-clock completion pulse, and for loads it also returns the fetched word.

Stores run a fixed four-clock pattern. The address goes out first and the data bus is driven one clock later. The write strobe pulses after that and is released one clock before the access ends. Loads put out the address and then hold the output-enable strobe low for a number of clocks worked out from the memory access time and the clock period. The data pins are sampled on the last of those clocks. Requests that arrive while an access is running are dropped, so the processor side must wait for the completion pulse before it issues the next request.

Top module: `sram_bus_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, chip select, output enable and write strobe are high (inactive), the data-bus drive enable is 0, the done pulse is 0 and the read-data register is 0.
- R2: A store accepted at a clock edge produces done high in the 4th cycle after that edge and in no other cycle. Done is low again in the 5th cycle.
- R3: Store phases, written as {cs_n, oe_n, we_n, dq_oe}: cycle 1 is 0110, cycle 2 is 0111, cycle 3 is 0101 and cycle 4 is 0111. The write strobe is never low while the data-bus drive is off.
- R4: Load phases: cycle 1 is 0110, cycles 2 to 5 are 0010 and cycle 6 is 0110 with done high. The read data shown in cycle 6 is the value on the data-in pins during cycle 5.
- R5: Output enable and the write strobe are never low in the same cycle, and the data-bus drive is never on while output enable is low.
- R6: Chip select is low whenever output enable or the write strobe is low. Chip select is high in every idle cycle.
- R7: The memory address and the write-data pins do not change while chip select stays low.
- R8: Done lasts exactly one clock. The read-data register changes only in a cycle where done is high, and a store leaves it unchanged.
- R9: A request present while an access is running, including in its done cycle, is ignored. No new access starts, and the memory contents at the ignored address are unchanged.
- R10: The number of output-enable clocks equals the memory access time divided by the clock period, rounded up: 65 ns over 20 ns gives 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (20 ns nominal period) |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, sampled only while idle |
| rd | input | 1 | 1 = load, 0 = store |
| addr | input | ADDR_W | Access address |
| wdata | input | DATA_W | Store data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Last loaded word, held |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data bus, outgoing value |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DATA_W | Data bus, incoming value |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |

## Verification
Two functions can fall in the same clock: the done pulse that ends an access and a new request from the processor. The bench holds a request high from the first cycle of a store through its done cycle and into the idle cycle that follows. It then checks that chip select stays high in that idle cycle, which shows that neither the request during the access nor the one in the done cycle started a new access. A later load from the ignored address must return the memory's earlier content.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WADDR,
        ST_WDATA,
        ST_WSTB,
        ST_WHOLD,
        ST_RADDR,
        ST_RWAIT,
        ST_REND
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
        logic done;
    } strobe_t;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    // Pin levels belonging to each phase of the sequence.
    function automatic strobe_t phase_pins(input seq_state_e s);
        strobe_t p;
        p = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0, done: 1'b0};
        case (s)
            ST_WADDR: p.cs_n = 1'b0;
            ST_WDATA: begin p.cs_n = 1'b0; p.dq_oe = 1'b1; end
            ST_WSTB:  begin p.cs_n = 1'b0; p.dq_oe = 1'b1; p.we_n = 1'b0; end
            ST_WHOLD: begin p.cs_n = 1'b0; p.dq_oe = 1'b1; p.done = 1'b1; end
            ST_RADDR: p.cs_n = 1'b0;
            ST_RWAIT: begin p.cs_n = 1'b0; p.oe_n = 1'b0; end
            ST_REND:  begin p.cs_n = 1'b0; p.done = 1'b1; end
            default:  ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int unsigned WE_CYCLES = 1,
    parameter int unsigned RD_WAIT   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       rd,
    output seq_state_e state_o,
    output logic       accept_o,
    output logic       capture_o
);
    localparam int unsigned MAXC  = (WE_CYCLES > RD_WAIT) ? WE_CYCLES : RD_WAIT;
    localparam int unsigned CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (req) state_d = rd ? ST_RADDR : ST_WADDR;
            ST_WADDR: state_d = ST_WDATA;
            ST_WDATA: state_d = ST_WSTB;
            ST_WSTB:  if (cnt_zero) state_d = ST_WHOLD;
            ST_WHOLD: state_d = ST_IDLE;
            ST_RADDR: state_d = ST_RWAIT;
            ST_RWAIT: if (cnt_zero) state_d = ST_REND;
            ST_REND:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WDATA)
                cnt_q <= CNT_W'(WE_CYCLES - 1);
            else if (state_q == ST_RADDR)
                cnt_q <= CNT_W'(RD_WAIT - 1);
            else if (!cnt_zero && (state_q == ST_WSTB || state_q == ST_RWAIT))
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign state_o   = state_q;
    assign accept_o  = (state_q == ST_IDLE) && req;
    assign capture_o = (state_q == ST_RWAIT) && cnt_zero;

endmodule

// File: rtl/sram_seq_regs.sv
module sram_seq_regs #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= addr_in;
                wdata_q <= wdata_in;
            end
            if (capture)
                rdata_q <= dq_in;
        end
    end
endmodule

// File: rtl/sram_bus_seq.sv
module sram_bus_seq
    import sram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W        = 16,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned CLK_PERIOD_PS = 20000,
    parameter int unsigned ACCESS_PS     = 65000,
    parameter int unsigned WE_CYCLES     = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    localparam int unsigned RD_WAIT = at_least_one(ceil_div(ACCESS_PS, CLK_PERIOD_PS));
    localparam int unsigned WE_LEN  = at_least_one(WE_CYCLES);

    seq_state_e state;
    logic       accept, capture;
    strobe_t    pins;

    sram_seq_fsm #(.WE_CYCLES(WE_LEN), .RD_WAIT(RD_WAIT)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .rd       (rd),
        .state_o  (state),
        .accept_o (accept),
        .capture_o(capture)
    );

    sram_seq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .capture (capture),
        .addr_in (addr),
        .wdata_in(wdata),
        .dq_in   (mem_dq_in),
        .addr_q  (mem_addr),
        .wdata_q (mem_dq_out),
        .rdata_q (rdata)
    );

    assign pins      = phase_pins(state);
    assign mem_cs_n  = pins.cs_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_dq_oe = pins.dq_oe;
    assign done      = pins.done;

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic [DATA_W-1:0] rdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n
);
    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    // R5
    no_drive_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);

    // R6
    cs_covers_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

    // R3
    data_before_we_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_dq_oe);

    // R3
    we_release_early_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (!mem_cs_n && mem_dq_oe));

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !$past(mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata) |-> done);
endmodule

bind sram_bus_seq sram_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .rdata     (rdata),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n)
);

// File: tb/test_sram_bus_seq.sv
`timescale 1ns/1ps
module test_sram_bus_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        req, rd;
    logic [15:0] addr, wdata;
    logic        done;
    logic [15:0] rdata, mem_addr, mem_dq_out, mem_dq_in;
    logic        mem_dq_oe, mem_cs_n, mem_oe_n, mem_we_n;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    sram_bus_seq i_sram_bus_seq (
        .clk(clk), .rst(rst), .req(req), .rd(rd), .addr(addr), .wdata(wdata),
        .done(done), .rdata(rdata), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    // Memory model: data valid only after output enable has been low 3 full clocks.
    logic [15:0] mem [256];
    logic [15:0] shadow [256];
    int          oe_cnt;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 16'(i * 3);
            oe_cnt <= 0;
        end else begin
            if (!mem_cs_n && !mem_we_n && mem_dq_oe) mem[mem_addr[7:0]] <= mem_dq_out;
            oe_cnt <= (!mem_cs_n && !mem_oe_n) ? oe_cnt + 1 : 0;
        end
    end

    assign mem_dq_in = (!mem_cs_n && !mem_oe_n && oe_cnt >= 3) ? mem[mem_addr[7:0]] : 16'hDEAD;

    typedef struct {
        bit          is_rd;
        logic [15:0] a;
        logic [15:0] d;
    } exp_t;
    exp_t sb[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] pins();
        return {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe};
    endfunction

    // Monitor: pop an expected item on each done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                chk("R9 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.is_rd) chk("R4 read data", {16'h0, rdata}, {16'h0, e.d});
                else         chk("R3 stored word", {16'h0, mem[e.a[7:0]]}, {16'h0, e.d});
            end
        end
    end

    // Driver: issue one access and check every phase; hold keeps req high into the first idle cycle.
    task automatic access(input bit is_rd, input logic [15:0] a, input logic [15:0] d, input bit hold);
        int len;
        exp_t e;
        len = is_rd ? 6 : 4;
        e.is_rd = is_rd; e.a = a;
        e.d = is_rd ? shadow[a[7:0]] : d;
        if (!is_rd) shadow[a[7:0]] = d;
        sb.push_back(e);
        req = 1'b1; rd = is_rd; addr = a; wdata = d;
        for (int c = 1; c <= len; c++) begin
            @(negedge clk);
            if (!hold) req = 1'b0;
            else addr = a ^ 16'h0055;
            chk("R7 address held", {16'h0, mem_addr}, {16'h0, a});
            if (is_rd) begin
                chk("R4 R10 read phase", {28'h0, pins()},
                    {28'h0, (c == 1 || c == 6) ? 4'b0110 : 4'b0010});
                chk("R4 done timing", {31'h0, done}, {31'h0, c == 6});
            end else begin
                chk("R3 write phase", {28'h0, pins()},
                    {28'h0, (c == 1) ? 4'b0110 : (c == 3) ? 4'b0101 : 4'b0111});
                chk("R2 done timing", {31'h0, done}, {31'h0, c == 4});
                if (c >= 2) chk("R7 data held", {16'h0, mem_dq_out}, {16'h0, d});
            end
        end
        @(negedge clk);
        chk("R6 idle after access", {28'h0, pins()}, {28'h0, 4'b1110});
        chk("R8 done one clock", {31'h0, done}, 32'h0);
        req = 1'b0;
        if (hold) begin
            @(negedge clk);
            chk("R9 no new access", {28'h0, pins()}, {28'h0, 4'b1110});
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; req = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
        for (int i = 0; i < 256; i++) shadow[i] = 16'(i * 3);
        repeat (3) @(negedge clk);
        chk("R1 reset pins", {28'h0, pins()}, {28'h0, 4'b1110});
        chk("R1 reset done", {31'h0, done}, 32'h0);
        chk("R1 reset rdata", {16'h0, rdata}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset pins", {28'h0, pins()}, {28'h0, 4'b1110});

        access(1'b0, 16'h0012, 16'hA5C3, 1'b0);
        access(1'b1, 16'h0012, 16'h0000, 1'b0);
        // R8: a store leaves rdata alone
        access(1'b0, 16'h0040, 16'h1234, 1'b0);
        chk("R8 rdata held after store", {16'h0, rdata}, {16'h0, 16'hA5C3});
        access(1'b1, 16'h0033, 16'h0000, 1'b0);
        // R9: request held through the store and its done cycle
        access(1'b0, 16'h0070, 16'h7E7E, 1'b1);
        access(1'b1, 16'h0070 ^ 16'h0055, 16'h0000, 1'b0);
        access(1'b1, 16'h0070, 16'h0000, 1'b0);
        for (int k = 0; k < 6; k++) begin
            access(1'b0, 16'(8'h90 + k), 16'(16'hC000 + k * 16'h0111), 1'b0);
            access(1'b1, 16'(8'h90 + k), 16'h0000, 1'b0);
        end
        access(1'b1, 16'h0040, 16'h0000, 1'b0);
        repeat (2) @(negedge clk);
        chk("R8 scoreboard drained", sb.size(), 0);
        finish_run();
    end
endmodule